// File: doc/BRIEF.md
# Quad DAC Serial Command Receiver

This block is the digital front end of a four-channel, 8-bit converter. It watches four asynchronous pins (a serial clock, a data line, an active-low load strobe and an active-low update strobe), oversamples them on a fast system clock, and assembles 11-bit commands from the data line. Each accepted command names one channel, carries a gain flag and an 8-bit code, and lands in that channel's holding register.

The holding registers feed a second rank of output registers that drive the converter. Whether a command reaches that second rank at once or waits depends on the update strobe. When the strobe is low as the load strobe falls, only the addressed channel's outputs change right away. When it is high, the command waits in the holding rank until the update strobe falls, and then all four channels change in the same cycle. Commands that are too short are thrown away, and the block raises a one-cycle error pulse. Everything after the pins is synchronous to the system clock. That clock must run at least four times faster than the serial clock.

Top module: `quadDacCmdRx`

## Requirements
- R1: After a synchronous reset, every channel's holding and output code is 0, every gain flag is 0 (x1), and all three pulse outputs are low.
- R2: One data bit is taken on each falling edge of the serial clock, most significant bit first. A frame holds a 2-bit channel number (0 to 3), then a gain bit (1 means x2), then an 8-bit code. Channel n appears on `codeOut[8n+7:8n]` and `gainOut[n]`.
- R3: If the update strobe is high when the load strobe falls, only the addressed holding register is written. No output changes, and `cmdDone` pulses for one cycle.
- R4: If the update strobe is low when the load strobe falls, the addressed channel's output code and gain take the new command in that same update. The other channels keep their outputs.
- R5: A falling edge of the update strobe copies all four holding registers into the output registers together, and `bcastDone` pulses for one cycle.
- R6: If more than 11 bits were clocked in before the load strobe falls, only the 11 most recent bits form the command.
- R7: If fewer than 11 bits were clocked in before the load strobe falls, the command is dropped. No register changes, `shortErr` pulses for one cycle, and `cmdDone` stays low.
- R8: The bit count and the shift contents clear on every falling edge of the load strobe, whether the command was accepted or not. A short frame sent after an accepted one is therefore rejected.
- R9: Each pin passes through two synchronizing flops before edge detection. A pin change made just before system edge k affects the registers at edge k+2, which makes the effect visible after the third rising edge.
- R10: If the load and update strobes fall in the same cycle, the command is written first, and the global copy includes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| serClk | input | 1 | Asynchronous serial clock; data taken on its falling edge |
| serData | input | 1 | Asynchronous serial data |
| loadN | input | 1 | Asynchronous load strobe; a falling edge latches the frame |
| ldacN | input | 1 | Asynchronous update strobe; its level selects immediate update, and its falling edge updates all channels |
| codeOut | output | 32 | Output codes, channel n in bits [8n+7:8n] |
| gainOut | output | 4 | Output gain flags, 1 means x2 |
| cmdDone | output | 1 | One-cycle pulse per accepted command |
| bcastDone | output | 1 | One-cycle pulse per global update |
| shortErr | output | 1 | One-cycle pulse per rejected short command |

## Verification
The bench targets four things: bit order, the choice between holding and immediate update, frame length at the edges, and the case where both strobes fall together. A design that shifted least significant bit first, or decoded the channel bits backwards, would place codes such as 0xA5 on the wrong bits or the wrong channel. A design that ignored the update-strobe level would move outputs early, or leave them unchanged. Frames of 14 bits and of 4, 5 and 7 bits check three things: that only the last 11 bits count, that short frames are rejected, and that the counter restarts after each load. A counter that failed to restart would accept the 4-bit frame that follows an accepted one. Firing both strobes in one cycle shows whether the global copy misses the command that lands in the same cycle.

// File: rtl/qdacPkg.sv
package qdacPkg;
  typedef struct packed {
    logic shiftEn;
    logic accept;
    logic clearShift;
    logic immediate;
    logic copyAll;
  } ctrlStrobes_t;
endpackage

// File: rtl/qdacSync.sv
module qdacSync #(
  parameter int NUM_SIG = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SIG-1:0] pinIn,
  output logic [NUM_SIG-1:0] levelOut,
  output logic [NUM_SIG-1:0] fallOut
);
  logic [NUM_SIG-1:0] stage1, stage2, prevLvl;

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_sig
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i]  <= 1'b1;
        stage2[i]  <= 1'b1;
        prevLvl[i] <= 1'b1;
      end else begin
        stage1[i]  <= pinIn[i];
        stage2[i]  <= stage1[i];
        prevLvl[i] <= stage2[i];
      end
    end
    assign levelOut[i] = stage2[i];
    assign fallOut[i]  = prevLvl[i] & ~stage2[i];
  end
endmodule

// File: rtl/qdacCtrl.sv
module qdacCtrl
  import qdacPkg::*;
#(
  parameter int CMD_W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clkFall,
  input  logic         loadFall,
  input  logic         ldacFall,
  input  logic         ldacLvl,
  output ctrlStrobes_t strobes,
  output logic         cmdDone,
  output logic         bcastDone,
  output logic         shortErr
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CMD_W);

  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic             frameFull;

  always_comb begin
    bitCntNext = bitCnt;
    if (clkFall && bitCnt != FULL) bitCntNext = bitCnt + 1'b1;
  end

  assign frameFull          = (bitCntNext == FULL);
  assign strobes.shiftEn    = clkFall;
  assign strobes.clearShift = loadFall;
  assign strobes.accept     = loadFall && frameFull;
  assign strobes.immediate  = loadFall && frameFull && !ldacLvl;
  assign strobes.copyAll    = ldacFall;

  always_ff @(posedge clk) begin
    if (rst || loadFall) bitCnt <= '0;
    else                 bitCnt <= bitCntNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdDone   <= 1'b0;
      bcastDone <= 1'b0;
      shortErr  <= 1'b0;
    end else begin
      cmdDone   <= loadFall && frameFull;
      bcastDone <= ldacFall;
      shortErr  <= loadFall && !frameFull;
    end
  end
endmodule

// File: rtl/qdacDatapath.sv
module qdacDatapath
  import qdacPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dataBit,
  input  ctrlStrobes_t             strobes,
  output logic [NUM_CH*CODE_W-1:0] codeOut,
  output logic [NUM_CH-1:0]        gainOut
);
  localparam int SEL_W = $clog2(NUM_CH);
  localparam int CMD_W = SEL_W + 1 + CODE_W;

  logic [CMD_W-1:0]  shiftReg, shiftNext;
  logic [SEL_W-1:0]  cmdSel;
  logic              cmdGain;
  logic [CODE_W-1:0] cmdCode;

  assign shiftNext = strobes.shiftEn ? {shiftReg[CMD_W-2:0], dataBit} : shiftReg;
  assign cmdSel    = shiftNext[CMD_W-1 -: SEL_W];
  assign cmdGain   = shiftNext[CODE_W];
  assign cmdCode   = shiftNext[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || strobes.clearShift) shiftReg <= '0;
    else                           shiftReg <= shiftNext;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] holdCode, holdCodeNext, outCode;
    logic              holdGain, holdGainNext, outGain;

    assign hit          = strobes.accept && (cmdSel == SEL_W'(ch));
    assign holdCodeNext = hit ? cmdCode : holdCode;
    assign holdGainNext = hit ? cmdGain : holdGain;

    always_ff @(posedge clk) begin
      if (rst) begin
        holdCode <= '0;
        holdGain <= 1'b0;
        outCode  <= '0;
        outGain  <= 1'b0;
      end else begin
        holdCode <= holdCodeNext;
        holdGain <= holdGainNext;
        if (strobes.copyAll) begin
          outCode <= holdCodeNext;
          outGain <= holdGainNext;
        end else if (strobes.immediate && hit) begin
          outCode <= cmdCode;
          outGain <= cmdGain;
        end
      end
    end

    assign codeOut[ch*CODE_W +: CODE_W] = outCode;
    assign gainOut[ch]                  = outGain;
  end
endmodule

// File: rtl/quadDacCmdRx.sv
module quadDacCmdRx
  import qdacPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     serClk,
  input  logic                     serData,
  input  logic                     loadN,
  input  logic                     ldacN,
  output logic [NUM_CH*CODE_W-1:0] codeOut,
  output logic [NUM_CH-1:0]        gainOut,
  output logic                     cmdDone,
  output logic                     bcastDone,
  output logic                     shortErr
);
  localparam int CMD_W = $clog2(NUM_CH) + 1 + CODE_W;

  logic [3:0]   syncLvl, syncFall;
  ctrlStrobes_t strobes;

  qdacSync #(.NUM_SIG(4)) u_sync (
    .clk(clk), .rst(rst),
    .pinIn({ldacN, loadN, serData, serClk}),
    .levelOut(syncLvl), .fallOut(syncFall)
  );

  qdacCtrl #(.CMD_W(CMD_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .clkFall(syncFall[0]), .loadFall(syncFall[2]),
    .ldacFall(syncFall[3]), .ldacLvl(syncLvl[3]),
    .strobes(strobes),
    .cmdDone(cmdDone), .bcastDone(bcastDone), .shortErr(shortErr)
  );

  qdacDatapath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst(rst),
    .dataBit(syncLvl[1]), .strobes(strobes),
    .codeOut(codeOut), .gainOut(gainOut)
  );
endmodule

// File: rtl/qdacChecker.sv
module qdacChecker #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CH*CODE_W-1:0] codeOut,
  input logic [NUM_CH-1:0]        gainOut,
  input logic                     cmdDone,
  input logic                     bcastDone,
  input logic                     shortErr
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (codeOut == '0 && gainOut == '0 && !cmdDone && !bcastDone && !shortErr));

  p_out_moves_only_on_event_r3: assert property (@(posedge clk) disable iff (rst)
    !($stable(codeOut) && $stable(gainOut)) |-> (cmdDone || bcastDone));

  p_bcast_single_r5: assert property (@(posedge clk) disable iff (rst)
    bcastDone |=> !bcastDone);

  p_short_no_change_r7: assert property (@(posedge clk) disable iff (rst)
    (shortErr && !bcastDone) |-> ($stable(codeOut) && $stable(gainOut)));

  p_short_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(shortErr && cmdDone));

  p_cmd_single_r9: assert property (@(posedge clk) disable iff (rst)
    cmdDone |=> !cmdDone);

  p_err_single_r9: assert property (@(posedge clk) disable iff (rst)
    shortErr |=> !shortErr);
endmodule

bind quadDacCmdRx qdacChecker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .codeOut(codeOut), .gainOut(gainOut),
  .cmdDone(cmdDone), .bcastDone(bcastDone), .shortErr(shortErr)
);

// File: tb/sim_quadDacCmdRx.sv
module sim_quadDacCmdRx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        serClk = 1'b1, serData = 1'b0, loadN = 1'b1, ldacN = 1'b1;
  logic [31:0] codeOut;
  logic [3:0]  gainOut;
  logic        cmdDone, bcastDone, shortErr;

  int tests = 0, fails = 0, cyc = 0;
  int nCmd = 0, nBc = 0, nErr = 0;
  bit done = 0;

  quadDacCmdRx u0 (
    .clk(clk), .rst(rst), .serClk(serClk), .serData(serData),
    .loadN(loadN), .ldacN(ldacN), .codeOut(codeOut), .gainOut(gainOut),
    .cmdDone(cmdDone), .bcastDone(bcastDone), .shortErr(shortErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit mc1, mc2, mc3, md1, md2, md3, ml1, ml2, ml3, ma1, ma2, ma3;
  bit q[$];
  int mIn[4], mInG[4], mOut[4], mOutG[4];
  bit mCmd, mBc, mErr;

  always @(posedge clk) begin
    if (rst) begin
      {mc1, mc2, mc3, md1, md2, md3, ml1, ml2, ml3, ma1, ma2, ma3} = '1;
      q.delete();
      for (int i = 0; i < 4; i++) begin
        mIn[i] = 0; mInG[i] = 0; mOut[i] = 0; mOutG[i] = 0;
      end
      mCmd = 0; mBc = 0; mErr = 0;
    end else begin
      bit cf, lf, af;
      cf = mc3 & ~mc2; lf = ml3 & ~ml2; af = ma3 & ~ma2;
      mCmd = 0; mBc = 0; mErr = 0;
      if (cf) begin
        q.push_back(md2);
        if (q.size() > 11) void'(q.pop_front());
      end
      if (lf) begin
        if (q.size() == 11) begin
          int sel, val;
          sel = q[0] * 2 + q[1];
          val = 0;
          for (int k = 3; k < 11; k++) val = val * 2 + q[k];
          mIn[sel] = val; mInG[sel] = q[2];
          if (!ma2) begin mOut[sel] = val; mOutG[sel] = q[2]; end
          mCmd = 1;
        end else mErr = 1;
        q.delete();
      end
      if (af) begin
        for (int i = 0; i < 4; i++) begin mOut[i] = mIn[i]; mOutG[i] = mInG[i]; end
        mBc = 1;
      end
      mc3 = mc2; mc2 = mc1; mc1 = serClk;
      md3 = md2; md2 = md1; md1 = serData;
      ml3 = ml2; ml2 = ml1; ml1 = loadN;
      ma3 = ma2; ma2 = ma1; ma1 = ldacN;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R9 timing, R2 placement)
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [31:0] ec;
      logic [3:0]  eg;
      for (int i = 0; i < 4; i++) begin
        ec[i*8 +: 8] = mOut[i][7:0];
        eg[i] = mOutG[i][0];
      end
      check(codeOut == ec, "R9 model codes", codeOut, ec);
      check(gainOut == eg, "R9 model gains", gainOut, eg);
      check({cmdDone, bcastDone, shortErr} == {mCmd, mBc, mErr}, "R9 model pulses",
            {cmdDone, bcastDone, shortErr}, {mCmd, mBc, mErr});
      nCmd += cmdDone; nBc += bcastDone; nErr += shortErr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input int n, input logic [15:0] bits);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); serData = bits[i]; serClk = 1'b1;
      idle(HALF_BIT);
      serClk = 1'b0;
      idle(HALF_BIT);
      serClk = 1'b1;
    end
    idle(HALF_BIT);
  endtask

  task automatic sendCmd(input int sel, input bit g, input logic [7:0] code);
    sendBits(11, {5'b0, sel[1:0], g, code});
  endtask

  task automatic pulseLoad();
    loadN = 1'b0; idle(4); loadN = 1'b1; idle(8);
  endtask

  task automatic pulseLdac();
    ldacN = 1'b0; idle(4); ldacN = 1'b1; idle(8);
  endtask

  initial begin
    int c0, b0, e0;
    idle(5);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check(codeOut == 32'h0 && gainOut == 4'h0, "R1 reset outputs", {gainOut, codeOut}, 0);
    check({cmdDone, bcastDone, shortErr} == 3'b0, "R1 reset pulses", {cmdDone, bcastDone, shortErr}, 0);
    idle(4);

    // R3 hold while update strobe high
    c0 = nCmd;
    sendCmd(1, 1, 8'hA5); pulseLoad();
    check(codeOut == 32'h0, "R3 output held", codeOut, 0);
    check(nCmd == c0 + 1, "R3 cmdDone pulse", nCmd, c0 + 1);

    // R5 and R2: global copy, MSB first, channel 1 placement
    b0 = nBc;
    pulseLdac();
    check(codeOut == 32'h0000A500, "R2 R5 channel 1 code", codeOut, 32'h0000A500);
    check(gainOut == 4'b0010, "R2 channel 1 gain", gainOut, 4'b0010);
    check(nBc == b0 + 1, "R5 bcastDone pulse", nBc, b0 + 1);

    // R4 immediate update with strobe held low
    ldacN = 1'b0; idle(12);
    sendCmd(2, 0, 8'h3C); pulseLoad();
    check(codeOut == 32'h003CA500, "R4 immediate channel 2", codeOut, 32'h003CA500);
    ldacN = 1'b1; idle(12);

    // R7 short frame rejected, holding regs untouched
    sendCmd(3, 1, 8'h81); pulseLoad();
    sendCmd(0, 0, 8'h7E); pulseLoad();
    check(codeOut == 32'h003CA500, "R3 outputs unchanged", codeOut, 32'h003CA500);
    e0 = nErr; c0 = nCmd;
    sendBits(7, 16'h005B); pulseLoad();
    check(nErr == e0 + 1, "R7 shortErr pulse", nErr, e0 + 1);
    check(nCmd == c0, "R7 no cmdDone", nCmd, c0);
    pulseLdac();
    check(codeOut == 32'h813CA57E, "R7 R5 all channels", codeOut, 32'h813CA57E);
    check(gainOut == 4'b1010, "R5 gains", gainOut, 4'b1010);

    // R6 over-long frame, last 11 bits used
    ldacN = 1'b0; idle(12);
    sendBits(14, {2'b0, 3'b101, 2'd0, 1'b1, 8'h55}); pulseLoad();
    check(codeOut == 32'h813CA555, "R6 last 11 bits", codeOut, 32'h813CA555);
    check(gainOut == 4'b1011, "R6 gain", gainOut, 4'b1011);

    // R8 counter restarts: short after accepted is rejected
    sendBits(5, 16'h0017); pulseLoad();
    sendCmd(1, 0, 8'h0F); pulseLoad();
    check(codeOut == 32'h813C0F55, "R8 full frame after short", codeOut, 32'h813C0F55);
    e0 = nErr;
    sendBits(4, 16'h000F); pulseLoad();
    check(nErr == e0 + 1, "R8 short after accepted", nErr, e0 + 1);
    check(codeOut == 32'h813C0F55, "R8 no change", codeOut, 32'h813C0F55);
    ldacN = 1'b1; idle(12);

    // R10 both strobes fall together
    b0 = nBc;
    sendCmd(2, 1, 8'h99);
    loadN = 1'b0; ldacN = 1'b0; idle(4);
    loadN = 1'b1; ldacN = 1'b1; idle(8);
    check(codeOut == 32'h81990F55, "R10 copy includes command", codeOut, 32'h81990F55);
    check(gainOut == 4'b1101, "R10 gains", gainOut, 4'b1101);
    check(nBc == b0 + 1, "R10 bcastDone", nBc, b0 + 1);

    idle(10);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule